// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Program Sequencer

This block sits behind the serial command decoder of a small byte-addressed non-volatile memory. It holds the protection settings (a two-bit block-protect level and a hardware-protect enable), the write-enable latch, a 32-byte page buffer and the array itself, which is modelled as a synchronous RAM. The decoder hands it single-cycle strobes: enable and disable writes, a status byte to program, a page start address followed by data bytes, and a commit strobe in the cycle the chip select is released. The block decides which of the buffered bytes may actually be programmed, runs a self-timed programming cycle of a parameterised number of clocks, and presents the status byte that a status read returns.

The controller is a four-state machine. `ST_IDLE` accepts enable/disable strobes and opens a transaction. A page start moves it to `ST_ARRAY_LOAD`, where data bytes fill the page buffer. An accepted status write moves it to `ST_STATUS_LOAD`. On commit, either load state moves to `ST_PROGRAM` when the write latch is set and there is work to do, and otherwise back to `ST_IDLE`. `ST_STATUS_LOAD` also returns to `ST_IDLE` when hardware protection becomes active before commit (cancel). `ST_PROGRAM` lasts exactly `CYCLE_LEN` clocks, programs the surviving bytes, applies any new protection settings, clears the write latch and returns to `ST_IDLE`.

Status byte, as the bench relies on it: bit 7 is the hardware-protect enable, bits 6 to 4 are zero, bit 3 and bit 2 are the upper and lower block-protect bits, bit 1 is the write latch, bit 0 is busy. The status data input uses the same positions for bit 7 and bits 3 to 2; its other bits are ignored. The protect pin input `wp_ni` is active low and synchronous to the clock.

Top module: `wg_write_guard`

## Requirements
- R1: After reset the status byte is 0x00 and busy is low; outside a programming cycle bits 6 to 4 and bit 0 of the status byte read 0.
- R2: A programming cycle keeps `busy_o` high for exactly `CYCLE_LEN` clocks, starting the clock after commit, and the status byte reads 0xFF throughout.
- R3: With block-protect level 0 nothing is protected, level 1 protects the upper quarter of the addresses, level 2 the upper half, level 3 every address; protected bytes are not written while the other bytes of the same page are.
- R4: When `wp_ni` is low and the protect enable is 1, a status write is refused (including an attempt to clear the enable), while array writes still follow only the write latch and the block-protect level.
- R5: A status write is cancelled if hardware protection becomes active before its commit; once its programming cycle has started, the protect pin has no effect on it.
- R6: A page write committed with the write latch at 0 starts no cycle and changes neither the array nor the status byte.
- R7: The write latch is set by the enable strobe and cleared by the disable strobe whatever the protect pin does; it clears at the end of every programming cycle, and also at a page commit in which no byte survives protection (no cycle starts then).
- R8: Within a page only the low 5 address bits advance per data byte; more than 32 bytes wrap and overwrite earlier bytes of the same page.
- R9: During a programming cycle every strobe (enable, disable, status write, page start, data, commit) is ignored.
- R10: The protect enable and block-protect bits change only at the end of a completed status programming cycle; a status write with the write latch at 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wp_ni | input | 1 | Protect pin, active low, synchronous |
| wen_set_i | input | 1 | Write-enable strobe |
| wen_clr_i | input | 1 | Write-disable strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_data_i | input | 8 | New status byte (bit 7, bits 3:2 used) |
| page_start_i | input | 1 | Opens a page write at `page_addr_i` |
| page_addr_i | input | ADDR_W | Start address of the page write |
| byte_push_i | input | 1 | Data byte strobe |
| byte_data_i | input | 8 | Data byte |
| commit_i | input | 1 | Chip-select release strobe |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data, one clock after the address |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The hardest situation to reach is a status write cancelled by the protect pin falling between the status strobe and the commit: it needs the protect enable already programmed to 1 by an earlier completed cycle, the pin high while the status strobe is accepted, and then a pin fall in the open transaction. The bench builds it in that order and then reads the status byte to show that neither the enable nor the latch moved. The block-protect behaviour is swept over all four levels, writing every page of a 256-byte array and reading every address against an arithmetic model, which also covers pages that are partly protected.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARRAY_LOAD,
        ST_STATUS_LOAD,
        ST_PROGRAM
    } wg_state_e;

    localparam logic [7:0] STATUS_BUSY = 8'hFF;
    localparam int         PAGE_W      = 5;
    localparam int         PAGE_BYTES  = 1 << PAGE_W;

endpackage

// File: rtl/wg_region_check.sv
module wg_region_check #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        level_i,
    output logic              prot_o
);

    always_comb begin
        unique case (level_i)
            2'd0: prot_o = 1'b0;
            2'd1: prot_o = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'd2: prot_o = addr_i[ADDR_W-1];
            2'd3: prot_o = 1'b1;
            default: prot_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wg_page_buffer.sv
module wg_page_buffer #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 5,
    localparam int PAGE_BYTES = 1 << PAGE_W,
    localparam int BASE_W = ADDR_W - PAGE_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  load_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  push_i,
    input  logic [7:0]            data_i,
    input  logic [PAGE_W-1:0]     rd_idx_i,
    output logic [BASE_W-1:0]     base_o,
    output logic [7:0]            data_o,
    output logic [PAGE_BYTES-1:0] valid_o
);

    logic [7:0]        slot_q [PAGE_BYTES];
    logic [PAGE_W-1:0] offs_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            offs_q  <= '0;
            base_o  <= '0;
            valid_o <= '0;
        end else if (load_i) begin
            offs_q  <= addr_i[PAGE_W-1:0];
            base_o  <= addr_i[ADDR_W-1:PAGE_W];
            valid_o <= '0;
        end else if (push_i) begin
            offs_q          <= offs_q + 1'b1;
            valid_o[offs_q] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_i && !load_i) begin
            slot_q[offs_q] <= data_i;
        end
    end

    assign data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/wg_cycle_timer.sv
module wg_cycle_timer #(
    parameter int CYCLE_LEN = 40,
    localparam int CNT_W = $clog2(CYCLE_LEN + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_o <= '0;
        end else if (run_i) begin
            count_o <= count_o + 1'b1;
        end else begin
            count_o <= '0;
        end
    end

    assign done_o = run_i && (count_o == CNT_W'(CYCLE_LEN - 1));

endmodule

// File: rtl/wg_array_ram.sv
module wg_array_ram #(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
        rdata_o <= cell_q[raddr_i];
    end

endmodule

// File: rtl/wg_write_guard.sv
module wg_write_guard
    import wg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CYCLE_LEN = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wp_ni,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              page_start_i,
    input  logic [ADDR_W-1:0] page_addr_i,
    input  logic              byte_push_i,
    input  logic [7:0]        byte_data_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [7:0]        status_o,
    output logic              busy_o
);

    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int CNT_W  = $clog2(CYCLE_LEN + 1);

    wg_state_e state_q, state_d;

    logic                  wen_q;
    logic                  wpen_q;
    logic [1:0]            bp_q;
    logic                  new_wpen_q;
    logic [1:0]            new_bp_q;
    logic                  prog_status_q;
    logic [PAGE_BYTES-1:0] keep_q;
    logic [PAGE_BYTES-1:0] keep_d;

    logic [BASE_W-1:0]     page_base;
    logic [7:0]            page_byte;
    logic [PAGE_BYTES-1:0] page_valid;
    logic [CNT_W-1:0]      cyc_count;
    logic                  cyc_done;

    logic                  hw_prot;
    logic                  open_array, open_status, status_cancel;
    logic                  commit_array, commit_status;
    logic                  start_array, start_status, empty_commit;
    logic                  in_idle;

    logic [PAGE_W-1:0]     prog_idx;
    logic                  prog_we;
    logic [ADDR_W-1:0]     prog_addr;

    // ---------------- event decode ----------------
    assign hw_prot       = !wp_ni && wpen_q;
    assign in_idle       = (state_q == ST_IDLE);
    assign open_array    = in_idle && page_start_i;
    assign open_status   = in_idle && !page_start_i && sr_wr_i && !hw_prot;
    assign status_cancel = (state_q == ST_STATUS_LOAD) && hw_prot;
    assign commit_array  = (state_q == ST_ARRAY_LOAD) && commit_i;
    assign commit_status = (state_q == ST_STATUS_LOAD) && commit_i && !hw_prot;
    assign start_array   = commit_array && wen_q && (|keep_d);
    assign empty_commit  = commit_array && wen_q && !(|keep_d);
    assign start_status  = commit_status && wen_q;

    // ---------------- per-byte protection ----------------
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic slot_prot;
        wg_region_check #(.ADDR_W(ADDR_W)) i_region (
            .addr_i  ({page_base, PAGE_W'(g)}),
            .level_i (bp_q),
            .prot_o  (slot_prot)
        );
        assign keep_d[g] = page_valid[g] && !slot_prot;
    end

    // ---------------- submodules ----------------
    wg_page_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_page (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (open_array),
        .addr_i   (page_addr_i),
        .push_i   (byte_push_i && (state_q == ST_ARRAY_LOAD)),
        .data_i   (byte_data_i),
        .rd_idx_i (prog_idx),
        .base_o   (page_base),
        .data_o   (page_byte),
        .valid_o  (page_valid)
    );

    wg_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (state_q == ST_PROGRAM),
        .count_o (cyc_count),
        .done_o  (cyc_done)
    );

    assign prog_idx  = cyc_count[PAGE_W-1:0];
    assign prog_addr = {page_base, prog_idx};
    assign prog_we   = (state_q == ST_PROGRAM) && !prog_status_q &&
                       (cyc_count < CNT_W'(PAGE_BYTES)) && keep_q[prog_idx];

    wg_array_ram #(.ADDR_W(ADDR_W)) i_ram (
        .clk_i   (clk_i),
        .we_i    (prog_we),
        .waddr_i (prog_addr),
        .wdata_i (page_byte),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (open_array) begin
                    state_d = ST_ARRAY_LOAD;
                end else if (open_status) begin
                    state_d = ST_STATUS_LOAD;
                end
            end
            ST_ARRAY_LOAD: begin
                if (start_array) begin
                    state_d = ST_PROGRAM;
                end else if (commit_array) begin
                    state_d = ST_IDLE;
                end
            end
            ST_STATUS_LOAD: begin
                if (status_cancel) begin
                    state_d = ST_IDLE;
                end else if (start_status) begin
                    state_d = ST_PROGRAM;
                end else if (commit_status) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PROGRAM: begin
                if (cyc_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- protection settings and latch ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wen_q         <= 1'b0;
            wpen_q        <= 1'b0;
            bp_q          <= 2'b00;
            new_wpen_q    <= 1'b0;
            new_bp_q      <= 2'b00;
            prog_status_q <= 1'b0;
            keep_q        <= '0;
        end else begin
            if (cyc_done || empty_commit) begin
                wen_q <= 1'b0;
            end else if (in_idle && wen_clr_i) begin
                wen_q <= 1'b0;
            end else if (in_idle && wen_set_i) begin
                wen_q <= 1'b1;
            end

            if (open_status) begin
                new_wpen_q <= sr_data_i[7];
                new_bp_q   <= sr_data_i[3:2];
            end

            if (start_array) begin
                keep_q        <= keep_d;
                prog_status_q <= 1'b0;
            end else if (start_status) begin
                keep_q        <= '0;
                prog_status_q <= 1'b1;
            end

            if (cyc_done && prog_status_q) begin
                wpen_q <= new_wpen_q;
                bp_q   <= new_bp_q;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy_o = (state_q == ST_PROGRAM);
        if (busy_o) begin
            status_o = STATUS_BUSY;
        end else begin
            status_o = {wpen_q, 3'b000, bp_q, wen_q, 1'b0};
        end
    end

endmodule

// File: rtl/wg_write_guard_chk.sv
module wg_write_guard_chk #(
    parameter int ADDR_W    = 8,
    parameter int CYCLE_LEN = 40
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [7:0]        status_o,
    input logic              busy_o,
    input logic              prog_we,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [1:0]        bp_q
);

    localparam int DEPTH = 1 << ADDR_W;

    int  busy_run;
    logic in_region;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_run <= 0;
        end else begin
            busy_run <= busy_o ? busy_run + 1 : 0;
        end
    end

    always_comb begin
        case (bp_q)
            2'd1:    in_region = (int'(prog_addr) >= (DEPTH / 4) * 3);
            2'd2:    in_region = (int'(prog_addr) >= DEPTH / 2);
            2'd3:    in_region = 1'b1;
            default: in_region = 1'b0;
        endcase
    end

    assert_idle_layout_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (status_o[6:4] == 3'b000 && !status_o[0]));

    assert_busy_all_ones_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (status_o == 8'hFF));

    assert_busy_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (busy_run == CYCLE_LEN));

    assert_no_protected_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_we |-> !in_region);

    assert_write_only_when_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_we |-> busy_o);

    assert_latch_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> !status_o[1]);

    assert_settings_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && $past(!busy_o)) |-> $stable({status_o[7], status_o[3:2]}));

endmodule

bind wg_write_guard wg_write_guard_chk #(
    .ADDR_W    (ADDR_W),
    .CYCLE_LEN (CYCLE_LEN)
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .status_o  (status_o),
    .busy_o    (busy_o),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .bp_q      (bp_q)
);

// File: tb/test_wg_write_guard.sv
`timescale 1ns/1ps
module test_wg_write_guard;

    localparam int ADDR_W    = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int CYCLE_LEN = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic wen_set = 1'b0, wen_clr = 1'b0, sr_wr = 1'b0;
    logic [7:0] sr_data = '0;
    logic page_start = 1'b0;
    logic [ADDR_W-1:0] page_addr = '0;
    logic byte_push = 1'b0;
    logic [7:0] byte_data = '0;
    logic commit = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data, status;
    logic busy;

    always #2 clk = ~clk;

    wg_write_guard #(.ADDR_W(ADDR_W), .CYCLE_LEN(CYCLE_LEN)) i_wg_write_guard (
        .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n),
        .wen_set_i(wen_set), .wen_clr_i(wen_clr),
        .sr_wr_i(sr_wr), .sr_data_i(sr_data),
        .page_start_i(page_start), .page_addr_i(page_addr),
        .byte_push_i(byte_push), .byte_data_i(byte_data),
        .commit_i(commit), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .status_o(status), .busy_o(busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [7:0] m_mem [DEPTH];
    bit m_wen = 0, m_wpen = 0;
    int m_bp = 0;

    function automatic logic [7:0] exp_status();
        return {m_wpen, 3'b000, 2'(m_bp), m_wen, 1'b0};
    endfunction

    function automatic bit prot_m(int a, int level);
        case (level)
            1: return a >= (DEPTH / 4) * 3;
            2: return a >= DEPTH / 2;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic pulse_set();
        wen_set = 1; tick(); wen_set = 0;
        m_wen = 1;
    endtask

    task automatic pulse_clr();
        wen_clr = 1; tick(); wen_clr = 0;
        m_wen = 0;
    endtask

    // status write followed by commit, model updated, cycle awaited
    task automatic status_write(input logic [7:0] d, input string req);
        bit go;
        int n;
        go = m_wen && !(!wp_n && m_wpen);
        sr_wr = 1; sr_data = d; tick(); sr_wr = 0;
        commit = 1; tick(); commit = 0;
        chk(busy == go, req, busy, go);
        if (go) begin
            chk(status == 8'hFF, "R2", status, 8'hFF);
            wait_idle(n);
            chk(n == CYCLE_LEN, "R2", n, CYCLE_LEN);
            m_wpen = d[7]; m_bp = d[3:2]; m_wen = 0;
        end
        chk(status == exp_status(), req, status, exp_status());
    endtask

    task automatic write_page(input int start, input int cnt, input int seed, input string req);
        bit pv [32];
        logic [7:0] pd [32];
        int base, surv, n;
        bit go;
        for (int i = 0; i < 32; i++) pv[i] = 0;
        base = start & ~31;
        page_start = 1; page_addr = ADDR_W'(start); tick(); page_start = 0;
        for (int k = 0; k < cnt; k++) begin
            int off;
            off = (start + k) & 31;
            byte_push = 1; byte_data = 8'((base + off) * 7 + seed + k);
            pv[off] = 1; pd[off] = byte_data;
            tick();
        end
        byte_push = 0;
        surv = 0;
        for (int i = 0; i < 32; i++) if (pv[i] && !prot_m(base + i, m_bp)) surv++;
        go = m_wen && surv > 0;
        commit = 1; tick(); commit = 0;
        chk(busy == go, req, busy, go);
        if (go) begin
            wait_idle(n);
            chk(n == CYCLE_LEN, "R2", n, CYCLE_LEN);
            for (int i = 0; i < 32; i++) if (pv[i] && !prot_m(base + i, m_bp)) m_mem[base + i] = pd[i];
        end
        if (m_wen) m_wen = 0;
        chk(status == exp_status(), "R7", status, exp_status());
    endtask

    task automatic verify_range(input int lo, input int hi, input string req);
        for (int a = lo; a < hi; a++) begin
            rd_addr = ADDR_W'(a); tick();
            chk(rd_data == m_mem[a], req, rd_data, m_mem[a]);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) tick();
        chk(status == 8'h00, "R1", status, 8'h00);
        chk(busy == 0, "R1", busy, 0);
        rst_n = 1; tick();
        chk(status == 8'h00, "R1", status, 8'h00);

        // R3 sweep: all levels, all pages, all addresses
        for (int level = 0; level < 4; level++) begin
            pulse_set();
            chk(status == exp_status(), "R7", status, exp_status());
            status_write(8'(level << 2), "R10");
            for (int p = 0; p < DEPTH / 32; p++) begin
                pulse_set();
                write_page(p * 32, 32, level * 16 + p, "R3");
            end
            verify_range(0, DEPTH, "R3");
        end

        // R6: write with latch clear, level 0
        pulse_set(); status_write(8'h00, "R10");
        write_page(64, 4, 200, "R6");
        verify_range(64, 68, "R6");

        // R8: 40 bytes from offset 30 wrap inside the page
        pulse_set(); write_page(2 * 32 + 30, 40, 99, "R8");
        verify_range(32, 128, "R8");

        // R7: every byte protected -> no cycle, latch cleared
        pulse_set(); status_write(8'h0C, "R10");
        pulse_set(); write_page(0, 8, 5, "R7");
        verify_range(0, 8, "R7");

        // R10: status write without latch
        status_write(8'h00, "R10");
        chk(status == 8'h0C, "R10", status, 8'h0C);

        // enable hardware protection bit, level 0
        pulse_set(); status_write(8'h80, "R10");

        // R5: pin falls in open status transaction -> cancelled
        pulse_set();
        sr_wr = 1; sr_data = 8'h00; tick(); sr_wr = 0;
        wp_n = 0; tick();
        commit = 1; tick(); commit = 0;
        chk(busy == 0, "R5", busy, 0);
        chk(status == 8'h82, "R5", status, 8'h82);

        // R4: pin low and enable set -> status write refused, array writable
        status_write(8'h00, "R4");
        chk(status == 8'h82, "R4", status, 8'h82);
        write_page(96, 5, 17, "R4");
        verify_range(96, 101, "R4");
        pulse_set(); pulse_clr();
        chk(status == 8'h80, "R7", status, 8'h80);

        // R5: pin falls after cycle start -> still applied
        wp_n = 1; pulse_set();
        sr_wr = 1; sr_data = 8'h08; tick(); sr_wr = 0;
        commit = 1; tick(); commit = 0;
        wp_n = 0;
        wait_idle(n);
        m_wpen = 0; m_bp = 2; m_wen = 0;
        chk(status == 8'h08, "R5", status, 8'h08);
        wp_n = 1;

        // R9: strobes during a programming cycle ignored
        pulse_set(); status_write(8'h00, "R10");
        pulse_set();
        page_start = 1; page_addr = 8'd32; tick(); page_start = 0;
        byte_push = 1; byte_data = 8'h5A; tick(); byte_push = 0;
        commit = 1; tick(); commit = 0;
        m_mem[32] = 8'h5A; m_wen = 0;
        chk(busy == 1, "R9", busy, 1);
        sr_wr = 1; sr_data = 8'h8C; tick(); sr_wr = 0;
        commit = 1; tick(); commit = 0;
        wen_set = 1; tick(); wen_set = 0;
        page_start = 1; page_addr = 8'd0; tick(); page_start = 0;
        byte_push = 1; byte_data = 8'hEE; tick(); byte_push = 0;
        wait_idle(n);
        chk(status == 8'h00, "R9", status, 8'h00);
        commit = 1; tick(); commit = 0;
        chk(busy == 0, "R9", busy, 0);
        verify_range(0, 1, "R9");
        verify_range(32, 33, "R9");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule